// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns a single multi-register load or store request into a stream of word addresses, one per selected register. A request carries a base address, a 16-bit register selection bitmap, one of four addressing modes and a writeback enable. The sequencer counts the selected registers, works out where the transfer window starts in memory, and then issues one address together with the register index on each cycle until every selected register has been served.

The four modes are increment-after, increment-before, decrement-after and decrement-before. In every mode the registers are served in ascending index order, so the lowest-numbered register always lands on the lowest address of the window. When the last transfer has gone out, the block pulses a completion strobe and presents the updated base value. It flags that value for writeback only when the request asked for it. A full-descending stack push maps onto decrement-before and the matching pop maps onto increment-after. The memory, the register file and the data path sit outside this block.

Top module: `blk_addr_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, `busy`, `xfer_valid`, `done` and `wb_valid` are all low.
- R2: Mode code 0 (increment-after) with N registers selected issues addresses base, base+4, … base+4N-4 and reports base+4N as the updated base.
- R3: Mode code 1 (increment-before) issues base+4 … base+4N and reports base+4N.
- R4: Mode code 2 (decrement-after) issues base-4N+4 … base and reports base-4N.
- R5: Mode code 3 (decrement-before) issues base-4N … base-4 and reports base-4N.
- R6: Registers are issued in ascending index order, one per cycle, and each address is 4 above the previous one. The lowest selected index gets the lowest address.
- R7: A request accepted on a clock edge produces transfers on the N following cycles, with `busy` high for exactly those cycles. N is the number of set bits in the bitmap.
- R8: `done` is high for one cycle, on the cycle right after the last transfer. During that cycle `wb_addr` holds the updated base, and `wb_valid` is high only if `wb_en` was set when the request was taken.
- R9: An empty bitmap produces no transfers. `done` is raised on the cycle after the request, with `wb_addr` equal to the base.
- R10: `start` is ignored while `busy` is high, and the transfer in progress continues unchanged.
- R11: A push in mode 3 followed by a pop of the same list in mode 0, starting from the pushed writeback value, covers the same addresses and returns the base to its original value.
- R12: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when not busy |
| base_addr | input | ADDR_W | Base address of the request |
| reg_list | input | NREG | Register selection bitmap |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_en | input | 1 | Request writeback of the updated base |
| busy | output | 1 | Transfers in progress |
| xfer_valid | output | 1 | `xfer_addr` / `xfer_reg` valid this cycle |
| xfer_addr | output | ADDR_W | Word address of the current transfer |
| xfer_reg | output | $clog2(NREG) | Register index of the current transfer |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base should be written back |
| wb_addr | output | ADDR_W | Updated base value, valid with `done` |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 16-entry bitmap and a 4-byte step. The 16-entry bitmap makes the full-list case reachable, with sixteen back-to-back transfers and the widest possible window. The 32-bit address lets a decrement-before request near zero wrap below address zero, so the wrap-around case is reached as well. Scattered bitmaps exercise the ordering rule. The push-then-pop pair links mode 3 to mode 0 through the reported writeback value.

// File: rtl/blkseq_pkg.sv
// Package: shared types for the block-transfer address sequencer.
// Assumes: the encoding of the mode code is fixed at the block's port.
package blkseq_pkg;

    // Addressing mode; the code values are visible on the mode port.
    typedef enum logic [1:0] {
        MODE_INC_AFTER  = 2'd0,
        MODE_INC_BEFORE = 2'd1,
        MODE_DEC_AFTER  = 2'd2,
        MODE_DEC_BEFORE = 2'd3
    } bs_mode_e;

endpackage

// File: rtl/bs_popcount.sv
// Module: counts the set bits of a vector.
// Assumes: CW is wide enough to hold the value N.
module bs_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Sum the bits of the vector.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/bs_lowest_pick.sv
// Module: finds the lowest set bit of a vector and gives both its index
// and a one-hot mask of it.
// Assumes: when the vector is zero, idx is 0 and any is low.
module bs_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    // Isolate the lowest set bit with two's-complement masking.
    always_comb begin
        onehot = vec & (~vec + N'(1));
        any    = |vec;
    end

    // Scan downward so that the lowest set index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // The mask must never select more than one register.
    always_comb begin
        assert_pick_onehot_R6: assert ($onehot0(onehot));
    end

endmodule

// File: rtl/bs_addr_plan.sv
// Module: derives the first transfer address and the updated base from
// the base, the mode and the register count.
// Assumes: arithmetic wraps modulo 2^AW; STEP is the word size in bytes.
module bs_addr_plan
    import blkseq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base,
    input  bs_mode_e      mode,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] first,
    output logic [AW-1:0] final_base
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] span;

    // Total byte span of the window.
    always_comb span = AW'(cnt) * STEP_V;

    // Window start and updated base for each mode.
    always_comb begin
        unique case (mode)
            MODE_INC_AFTER: begin
                first      = base;
                final_base = base + span;
            end
            MODE_INC_BEFORE: begin
                first      = base + STEP_V;
                final_base = base + span;
            end
            MODE_DEC_AFTER: begin
                first      = base - span + STEP_V;
                final_base = base - span;
            end
            default: begin
                first      = base - span;
                final_base = base - span;
            end
        endcase
    end

endmodule

// File: rtl/blk_addr_seq.sv
// Module: top of the block-transfer address sequencer. It takes a request,
// issues one word address and one register index per selected register in
// ascending order, then pulses done with the updated base.
// Assumes: start is ignored while busy; a request may be taken in the same
// cycle that done is high.
module blk_addr_seq
    import blkseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4,
    localparam int IDX_W = $clog2(NREG),
    localparam int CNT_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREG-1:0]   reg_list,
    input  logic [1:0]        mode,
    input  logic              wb_en,
    output logic              busy,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [IDX_W-1:0]  xfer_reg,
    output logic              done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic              busy_q;
    logic              done_q;
    logic              wb_en_q;
    logic [NREG-1:0]   pend_q;
    logic [NREG-1:0]   pend_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_q;
    logic [CNT_W-1:0]  req_cnt;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_oh;
    logic              accept;

    bs_popcount #(.N(NREG), .CW(CNT_W)) u_count (
        .vec (reg_list),
        .cnt (req_cnt)
    );

    bs_addr_plan #(.AW(ADDR_W), .CW(CNT_W), .STEP(STEP)) u_plan (
        .base       (base_addr),
        .mode       (bs_mode_e'(mode)),
        .cnt        (req_cnt),
        .first      (plan_first),
        .final_base (plan_final)
    );

    bs_lowest_pick #(.N(NREG), .IW(IDX_W)) u_pick (
        .vec    (pend_q),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // A request is taken only when no transfer is running.
    always_comb accept = start & ~busy_q;

    // Registers still pending after the current transfer.
    always_comb pend_nxt = pend_q & ~pick_oh;

    // Sequencing state: take a request, step through the list, flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            wb_en_q <= 1'b0;
            pend_q  <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                pend_q  <= reg_list;
                addr_q  <= plan_first;
                wb_q    <= plan_final;
                wb_en_q <= wb_en;
                if (reg_list == '0) done_q <= 1'b1;
                else                busy_q <= 1'b1;
            end else if (busy_q) begin
                pend_q <= pend_nxt;
                addr_q <= addr_q + STEP_V;
                if (pend_nxt == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Drive the outputs straight from state.
    always_comb begin
        busy       = busy_q;
        xfer_valid = busy_q & pick_any;
        xfer_addr  = addr_q;
        xfer_reg   = pick_idx;
        done       = done_q;
        wb_valid   = done_q & wb_en_q;
        wb_addr    = wb_q;
    end

    // Consecutive transfers step the address up by one word.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_addr == $past(xfer_addr) + STEP_V));

    // Consecutive transfers use strictly rising register indices.
    assert_reg_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_reg > $past(xfer_reg)));

    // The end of a run is always marked by done.
    assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // Writeback is flagged only together with done.
    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    // Done and busy are never high together.
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // While busy, a transfer is issued on every cycle.
    assert_valid_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> xfer_valid);

    // A start while busy leaves the address stream undisturbed.
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !$past(start)) |=> (busy ? (xfer_addr == $past(xfer_addr) + STEP_V) : done));

endmodule

// File: tb/test_blk_addr_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected transfers and the
// completion result, and a monitor pops and compares them as they appear.
module test_blk_addr_seq;

    localparam int AW = 32;
    localparam int NR = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [NR-1:0] reg_list = '0;
    logic [1:0]    mode = 2'd0;
    logic          wb_en = 1'b0;
    logic          busy, xfer_valid, done, wb_valid;
    logic [AW-1:0] xfer_addr, wb_addr;
    logic [IW-1:0] xfer_reg;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    logic [AW+IW-1:0] exp_x[$];
    logic [AW:0]      exp_d[$];
    logic [AW-1:0]    seen[$];

    always #2.5 clk = ~clk;

    blk_addr_seq i_blk_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .mode(mode), .wb_en(wb_en), .busy(busy),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
        .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: compare every transfer and completion against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_valid) begin
                seen.push_back(xfer_addr);
                if (exp_x.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected transfer", {28'd0, xfer_reg, xfer_addr}, 64'd0);
                end else begin
                    logic [AW+IW-1:0] e;
                    e = exp_x.pop_front();
                    chk(xfer_addr == e[AW-1:0], cur_req, "xfer_addr", xfer_addr, e[AW-1:0]);
                    chk(xfer_reg == e[AW+IW-1:AW], cur_req, "xfer_reg", xfer_reg, e[AW+IW-1:AW]);
                end
            end
            if (done) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected done", 64'd1, 64'd0);
                end else begin
                    logic [AW:0] d;
                    d = exp_d.pop_front();
                    chk(wb_valid == d[AW], cur_req, "wb_valid (R8)", wb_valid, d[AW]);
                    chk(wb_addr == d[AW-1:0], cur_req, "wb_addr", wb_addr, d[AW-1:0]);
                end
            end
        end
    end

    // Driver: queue the expected results, issue the request, time the run.
    task automatic run(input logic [AW-1:0] b, input logic [NR-1:0] lst,
                       input logic [1:0] m, input bit we, input bit poke,
                       input string req, output logic [AW-1:0] wb_out);
        int n = 0;
        int cyc;
        logic [AW-1:0] first, fin, a;
        cur_req = req;
        for (int i = 0; i < NR; i++) if (lst[i]) n++;
        case (m)
            2'd0: begin first = b;                     fin = b + AW'(4 * n); end
            2'd1: begin first = b + 4;                 fin = b + AW'(4 * n); end
            2'd2: begin first = b - AW'(4 * n) + 4;    fin = b - AW'(4 * n); end
            default: begin first = b - AW'(4 * n);     fin = b - AW'(4 * n); end
        endcase
        wb_out = fin;
        a = first;
        for (int i = 0; i < NR; i++) begin
            if (lst[i]) begin
                exp_x.push_back({IW'(i), a});
                a = a + 4;
            end
        end
        exp_d.push_back({we, fin});
        seen.delete();
        @(negedge clk);
        start = 1'b1; base_addr = b; reg_list = lst; mode = m; wb_en = we;
        @(negedge clk);
        start = 1'b0; base_addr = 32'hDEAD_BEE0; reg_list = '1; wb_en = ~we;
        cyc = 1;
        while (!done && cyc < 64) begin
            if (poke && cyc == 2) begin
                start = 1'b1; base_addr = 32'h0BAD_0000; reg_list = 16'h0001; mode = 2'd1;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        #1;
        chk(cyc == n + 1, req, "cycles to done (R7)", cyc, n + 1);
        chk(exp_x.size() == 0, req, "transfers left over (R7)", exp_x.size(), 0);
        chk(exp_d.size() == 0, req, "done results left over", exp_d.size(), 0);
        @(negedge clk);
        #1;
        chk(!done && !busy, req, "idle after done (R8)", {busy, done}, 0);
    endtask

    initial begin
        logic [AW-1:0] wb1, wb2;
        logic [AW-1:0] push_seen[$];
        // R1: reset holds everything low even with start asserted.
        start = 1'b1; reg_list = 16'h00FF;
        repeat (3) @(negedge clk);
        chk({busy, xfer_valid, done, wb_valid} == 0, "R1", "outputs in reset",
            {busy, xfer_valid, done, wb_valid}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, xfer_valid, done, wb_valid} == 0, "R1", "outputs after reset",
            {busy, xfer_valid, done, wb_valid}, 0);

        run(32'h0000_2000, 16'h000F, 2'd0, 1'b1, 1'b0, "R2", wb1);
        run(32'h0000_2000, 16'h8001, 2'd1, 1'b1, 1'b0, "R3", wb1);
        run(32'h0000_3000, 16'h0F0F, 2'd2, 1'b1, 1'b0, "R4", wb1);
        run(32'h0000_3000, 16'h0421, 2'd3, 1'b0, 1'b0, "R5", wb1);
        run(32'h0000_0100, 16'hFFFF, 2'd0, 1'b1, 1'b0, "R7", wb1);
        run(32'h0000_0500, 16'h0000, 2'd1, 1'b1, 1'b0, "R9", wb1);
        run(32'h0000_0500, 16'h0000, 2'd3, 1'b0, 1'b0, "R9", wb1);
        run(32'h0000_4000, 16'hA5A5, 2'd3, 1'b1, 1'b1, "R10", wb1);
        run(32'h0000_0008, 16'h00FF, 2'd3, 1'b1, 1'b0, "R12", wb1);
        run(32'hFFFF_FFF0, 16'h0F00, 2'd1, 1'b1, 1'b0, "R12", wb1);
        run(32'h0000_6000, 16'h4000, 2'd2, 1'b1, 1'b0, "R6", wb1);

        // R11: push with decrement-before, pop with increment-after.
        run(32'h0000_1000, 16'h40F1, 2'd3, 1'b1, 1'b0, "R11", wb1);
        push_seen = seen;
        run(wb1, 16'h40F1, 2'd0, 1'b1, 1'b0, "R11", wb2);
        chk(wb2 == 32'h0000_1000, "R11", "base restored", wb2, 32'h0000_1000);
        chk(push_seen == seen, "R11", "same address set", seen.size(), push_seen.size());

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule